// File: doc/BRIEF.md
# SPI Controller with Status Flags

A byte-wide SPI peripheral sitting on a small register bus. Software sets it up through a control register, watches a status register, and moves bytes through a data register. As a master it makes SCK from the system clock through a four-entry divider table and shifts one byte per transfer, most significant bit first, on MOSI while it samples MISO. As a slave it follows an external SCK while its select input is low, takes bits from MOSI and drives its loaded byte on MISO.

Received bytes land in a holding register apart from the shifter, so software can read the last byte while the next one is on the wire. Transmit has only the shifter: a write during a transfer is refused and flagged. If the select input is pulled low while the block is master, it records a mode fault and steps out of master mode. An interrupt output combines the completion and fault flags under an enable bit.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control register reads 0x04 (only the clock-phase bit set), the status register reads 0x00 and `irq` is low.
- R2: Register addresses are 0 = control, 1 = status, 2 = data. Control bits are [7] interrupt enable, [6] enable, [5] wired-OR (stored only), [4] master, [3] clock polarity, [2] clock phase, [1:0] rate. Status bits are [7] done, [6] collision, [4] mode fault, and the other bits read 0.
- R3: As master, rate codes 00, 01, 10 and 11 give an SCK period of 2, 4, 16 and 32 system clocks. SCK rests at the polarity bit when idle. A write to the data register at clock edge T makes SCK toggle every half period from edge T, 16 times in all.
- R4: Bits move MSB first. With MOSI looped to MISO, the byte that is written is the byte that is received, in all four polarity/phase modes. With MISO held at 0 the byte received is 0x00, and with MISO held at 1 it is 0xFF.
- R5: The done flag is set on the clock edge of the sixteenth SCK edge. Reading the data register returns the byte received and clears the done flag.
- R6: Received data is held in a buffer of its own. A data read made while a later transfer is shifting returns the previous byte.
- R7: A data-register write made while a transfer is running sets the collision flag and is discarded. The byte in flight is not changed.
- R8: The collision flag clears only when the status register is read with the flag set and the data register is then accessed. A data read before that status read leaves the flag set.
- R9: The select input, once synchronised and low while master and enable are set, raises the mode-fault flag. This happens on the third clock edge after the change. It clears master and enable and aborts the transfer without setting the done flag.
- R10: The mode-fault flag clears only when the status register is read with the flag set and the control register is then written.
- R11: `irq` is high exactly when interrupt enable is 1 and the done flag or the mode-fault flag is set.
- R12: As slave, with enable set, master clear and select low, the block samples MOSI and drives MISO with the loaded byte, MSB first, under the selected polarity and phase. After 16 SCK edges it sets the done flag and buffers the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (applies read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | SCK driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_o | output | 1 | Serial data out in slave mode |
| sck_i | input | 1 | SCK from an external master |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Active-low select input |

## Verification
In master mode SCK and the done flag are due at known cycles. After the data write taken at edge T, the k-th SCK toggle comes at edge T + k·half, and the done flag and the receive buffer update at edge T + 16·half. The bench reproduces that count for each cycle and compares SCK, the done bit and `irq` at every falling clock edge. The select input passes through a two-stage synchroniser, so the mode fault is checked four cycles after the select changes, which is one cycle past its due edge. Slave stimulus holds each SCK phase for eight clocks, so the synchroniser lag has settled before MISO is sampled.

// File: rtl/spi_ctl_pkg.sv
// Package: shared constants, control register layout and the rate table
// for the SPI controller. Assumes an 8-bit register bus and 8-bit frames.
package spi_ctl_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int HALF_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_WCOL_BIT = 6;
    localparam int STAT_MODF_BIT = 4;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       wired_or;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{irq_en: 1'b0, enable: 1'b0, wired_or: 1'b0,
                                     master: 1'b0, cpol: 1'b0, cpha: 1'b1,
                                     rate: 2'b00};

    // Half of the SCK period in system clocks for each rate code.
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
        case (rate)
            2'b00:   return 5'd1;
            2'b01:   return 5'd2;
            2'b10:   return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; each bit resets to its RST_VAL bit.
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the inputs through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_clkgen.sv
// Module: master SCK timing. Pulses tick once per half SCK period while
// run is high; the counter restarts whenever run drops.
module spi_clkgen #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt;

    assign tick = run && (cnt == half - HALF_W'(1));

    // Count system clocks inside each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + HALF_W'(1);
    end

endmodule

// File: rtl/spi_shift.sv
// Module: MSB-first shift engine shared by master and slave. Counts SCK
// edges, samples the serial input on sample edges (parity set by cpha),
// shifts on the others, and pulses done on the last edge together with
// the assembled byte. Assumes one edge pulse per SCK transition.
module spi_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              start,
    input  logic              sck_edge,
    input  logic              cpha,
    input  logic              abort,
    input  logic              in_bit,
    output logic              out_bit,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int EDGES  = 2 * BYTE_W;
    localparam int ECNT_W = $clog2(EDGES);
    localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);

    logic [BYTE_W-1:0] sreg;
    logic [ECNT_W-1:0] ecnt;
    logic              active;
    logic              rx_bit;
    logic              sample_edge;
    logic              last_edge;

    assign sample_edge = (ecnt[0] == cpha);
    assign last_edge   = (ecnt == LAST_EDGE);
    assign out_bit     = sreg[BYTE_W-1];
    assign busy        = active;
    assign done        = sck_edge && last_edge && !abort;
    assign rx_byte     = {sreg[BYTE_W-2:0], (cpha ? in_bit : rx_bit)};

    // Load, count edges, sample and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            ecnt   <= '0;
            active <= 1'b0;
            rx_bit <= 1'b0;
        end else if (abort) begin
            ecnt   <= '0;
            active <= 1'b0;
            if (load) sreg <= load_byte;
        end else begin
            if (load)  sreg   <= load_byte;
            if (start) active <= 1'b1;
            if (sck_edge) begin
                if (sample_edge) rx_bit <= in_bit;
                if (!sample_edge && !(cpha && ecnt == '0))
                    sreg <= {sreg[BYTE_W-2:0], rx_bit};
                if (last_edge) begin
                    ecnt   <= '0;
                    active <= 1'b0;
                end else begin
                    ecnt   <= ecnt + ECNT_W'(1);
                    active <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_ctl.sv
// Module: SPI controller top. Holds the control, status and receive
// registers, the bus decode and the flag-clear sequences, and steers the
// shift engine between master (internal SCK) and slave (synchronised SCK).
// Assumes the bus strobes last one cycle; reads return data combinationally
// and apply side effects on the clock edge.
module spi_ctl
    import spi_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              miso_o,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    input  logic              ss_n_i
);

    ctrl_t             ctrl;
    logic              spif, wcol, modf;
    logic              wcol_arm, modf_arm;
    logic [REG_W-1:0]  rx_buf;
    logic [2:0]        sync_q;
    logic              ss_s, sck_s, mosi_s, sck_d;
    logic              sck_q;
    logic              is_master, is_slave, modf_hit;
    logic              ctrl_wr, stat_rd, data_wr, data_rd;
    logic              busy, done, out_bit, m_tick, s_edge, sck_edge, abort, load;
    logic [REG_W-1:0]  rx_byte;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i, mosi_i}), .q(sync_q)
    );
    assign {ss_s, sck_s, mosi_s} = sync_q;

    assign is_master = ctrl.enable && ctrl.master;
    assign is_slave  = ctrl.enable && !ctrl.master;
    assign modf_hit  = is_master && !ss_s;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
    assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);
    assign data_rd = bus_rd && (bus_addr == ADDR_DATA);

    spi_clkgen #(.HALF_W(HALF_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(is_master && busy),
        .half(half_period(ctrl.rate)), .tick(m_tick)
    );

    assign s_edge   = is_slave && !ss_s && (sck_s != sck_d);
    assign sck_edge = is_master ? m_tick : s_edge;
    assign abort    = !ctrl.enable || modf_hit || (is_slave && ss_s);
    assign load     = data_wr && !busy;

    spi_shift #(.BYTE_W(REG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_byte(bus_wdata),
        .start(load && is_master), .sck_edge(sck_edge), .cpha(ctrl.cpha),
        .abort(abort), .in_bit(is_master ? miso_i : mosi_s),
        .out_bit(out_bit), .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    // Control register, mode-fault takeover and the master SCK level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= CTRL_RESET;
            sck_d <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata);
            if (modf_hit) begin
                ctrl.master <= 1'b0;
                ctrl.enable <= 1'b0;
            end
            if (is_master && busy) begin
                if (m_tick) sck_q <= ~sck_q;
            end else begin
                sck_q <= ctrl.cpol;
            end
        end
    end

    // Status flags, their clear sequences and the receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif     <= 1'b0;
            wcol     <= 1'b0;
            modf     <= 1'b0;
            wcol_arm <= 1'b0;
            modf_arm <= 1'b0;
            rx_buf   <= '0;
        end else begin
            if (done) begin
                spif   <= 1'b1;
                rx_buf <= rx_byte;
            end else if (data_rd) begin
                spif   <= 1'b0;
            end

            if (data_wr && busy) begin
                wcol     <= 1'b1;
                wcol_arm <= 1'b0;
            end else if (wcol_arm && (data_rd || data_wr)) begin
                wcol     <= 1'b0;
                wcol_arm <= 1'b0;
            end else if (stat_rd && wcol) begin
                wcol_arm <= 1'b1;
            end

            if (modf_hit) begin
                modf     <= 1'b1;
                modf_arm <= 1'b0;
            end else if (modf_arm && ctrl_wr) begin
                modf     <= 1'b0;
                modf_arm <= 1'b0;
            end else if (stat_rd && modf) begin
                modf_arm <= 1'b1;
            end
        end
    end

    // Read mux for the register bus.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_STAT: begin
                bus_rdata[STAT_DONE_BIT] = spif;
                bus_rdata[STAT_WCOL_BIT] = wcol;
                bus_rdata[STAT_MODF_BIT] = modf;
            end
            ADDR_DATA: bus_rdata = rx_buf;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq    = ctrl.irq_en && (spif || modf);
    assign sck_o  = sck_q;
    assign mosi_o = is_master ? out_bit : 1'b0;
    assign miso_o = is_slave  ? out_bit : 1'b0;

endmodule

// File: rtl/spi_ctl_chk.sv
// Checker: temporal properties of the SPI controller, bound to spi_ctl.
module spi_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       busy,
    input logic       done,
    input logic       spif,
    input logic       wcol,
    input logic       modf,
    input logic [7:0] ctrl_q
);

    assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif);

    assert_flag_means_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spif) |-> !busy);

    assert_busy_write_collides_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && busy) |=> wcol);

    assert_fault_drops_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf) |-> (!ctrl_q[4] && !ctrl_q[6]));

    assert_data_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && !done) |=> !spif);

endmodule

bind spi_ctl spi_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .busy(busy), .done(done), .spif(spif), .wcol(wcol),
    .modf(modf), .ctrl_q(ctrl)
);

// File: tb/spi_ctl_tb.sv
module spi_ctl_tb;
    import spi_ctl_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, mosi_o, miso_o, miso_i;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    int         miso_mode = 0;
    int         n_checks = 0, n_fail = 0;
    logic [7:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    // 0: loopback, 1: held low, 2: held high
    assign miso_i = (miso_mode == 0) ? mosi_o : (miso_mode == 2);

    spi_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_o(miso_o),
        .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i), .ss_n_i(ss_n_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Cycle-by-cycle model of one master transfer: SCK, done flag and irq.
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx_exp,
                               input logic [1:0] rate, input bit cpol,
                               input bit cpha, input bit ie);
        int half;
        logic [7:0] d;
        half = (rate == 2'd0) ? 1 : (rate == 2'd1) ? 2 : (rate == 2'd2) ? 8 : 16;
        bus_write(ADDR_CTRL, {ie, 1'b1, 1'b0, 1'b1, cpol, cpha, rate});
        bus_write(ADDR_DATA, tx);
        bus_addr = ADDR_STAT;
        #1;
        for (int j = 0; j <= 16 * half + 1; j++) begin
            int  e;
            bit  fin;
            bit  exp_sck;
            e       = j / half;
            fin     = (e >= 16);
            exp_sck = fin ? cpol : (cpol ^ e[0]);
            check(sck_o === exp_sck, "R3 sck level", sck_o, exp_sck);
            check(bus_rdata[7] === fin, "R5 done flag timing", bus_rdata[7], fin);
            check(irq === (ie && fin), "R11 irq", irq, ie && fin);
            @(negedge clk);
            #1;
        end
        bus_read(ADDR_DATA, d);
        check(d == rx_exp, "R4 received byte", d, rx_exp);
        peek(ADDR_STAT, d);
        check(d[7] == 1'b0, "R5 data read clears done", d[7], 0);
        check(irq == 1'b0, "R11 irq after clear", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset values
        peek(ADDR_CTRL, rd);
        check(rd == 8'h04, "R1 control reset", rd, 8'h04);
        peek(ADDR_STAT, rd);
        check(rd == 8'h00, "R1 status reset", rd, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        bus_write(ADDR_CTRL, 8'h20);
        peek(ADDR_CTRL, rd);
        check(rd == 8'h20, "R2 wired-or bit stored", rd, 8'h20);

        // R3 / R4 / R5 / R11: all rates and modes, loopback
        master_xfer(8'hA5, 8'hA5, 2'b00, 1'b0, 1'b0, 1'b0);
        master_xfer(8'h3C, 8'h3C, 2'b01, 1'b0, 1'b1, 1'b1);
        master_xfer(8'h81, 8'h81, 2'b10, 1'b1, 1'b0, 1'b0);
        master_xfer(8'h5E, 8'h5E, 2'b11, 1'b1, 1'b1, 1'b1);

        // R4: MISO held low / high
        miso_mode = 1;
        master_xfer(8'h5A, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0);
        miso_mode = 2;
        master_xfer(8'h5A, 8'hFF, 2'b01, 1'b1, 1'b0, 1'b0);
        miso_mode = 0;

        // R6: receive buffer holds previous byte during next transfer
        bus_write(ADDR_CTRL, 8'h50);
        bus_write(ADDR_DATA, 8'h11);
        repeat (20) @(negedge clk);
        bus_write(ADDR_DATA, 8'h22);
        bus_read(ADDR_DATA, rd);
        check(rd == 8'h11, "R6 buffered byte during shift", rd, 8'h11);
        repeat (20) @(negedge clk);
        bus_read(ADDR_DATA, rd);
        check(rd == 8'h22, "R6 next byte", rd, 8'h22);

        // R7: write collision, write discarded
        bus_write(ADDR_DATA, 8'h33);
        bus_write(ADDR_DATA, 8'h44);
        peek(ADDR_STAT, rd);
        check(rd[6] == 1'b1, "R7 collision flag", rd[6], 1);
        repeat (20) @(negedge clk);
        bus_read(ADDR_DATA, rd);
        check(rd == 8'h33, "R7 in-flight byte unchanged", rd, 8'h33);

        // R8: clear sequence
        peek(ADDR_STAT, rd);
        check(rd[6] == 1'b1, "R8 data read alone keeps collision", rd[6], 1);
        bus_read(ADDR_STAT, rd);
        bus_read(ADDR_DATA, rd);
        peek(ADDR_STAT, rd);
        check(rd[6] == 1'b0, "R8 collision cleared", rd[6], 0);

        // R9 / R11: mode fault during a transfer
        bus_write(ADDR_CTRL, 8'hD3);
        bus_write(ADDR_DATA, 8'hAA);
        repeat (10) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        peek(ADDR_STAT, rd);
        check(rd[4] == 1'b1, "R9 mode fault flag", rd[4], 1);
        check(rd[7] == 1'b0, "R9 aborted transfer not done", rd[7], 0);
        check(irq == 1'b1, "R11 irq on mode fault", irq, 1);
        peek(ADDR_CTRL, rd);
        check(rd == 8'h83, "R9 master and enable cleared", rd, 8'h83);
        bus_write(ADDR_DATA, 8'h77);
        peek(ADDR_STAT, rd);
        check(rd[6] == 1'b0, "R9 no collision after abort", rd[6], 0);

        // R10: mode-fault clear sequence
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(ADDR_CTRL, 8'h50);
        peek(ADDR_STAT, rd);
        check(rd[4] == 1'b1, "R10 control write alone keeps fault", rd[4], 1);
        bus_read(ADDR_STAT, rd);
        bus_write(ADDR_CTRL, 8'h50);
        peek(ADDR_STAT, rd);
        check(rd[4] == 1'b0, "R10 fault cleared", rd[4], 0);

        // R12: slave transfer, polarity 0, phase 0
        bus_write(ADDR_CTRL, 8'h40);
        bus_write(ADDR_DATA, 8'hC3);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] tx_s;
            logic [7:0] rx_s;
            tx_s = 8'hC3;
            rx_s = 8'h96;
            mosi_i = rx_s[i];
            repeat (8) @(negedge clk);
            check(miso_o == tx_s[i], "R12 slave MISO bit", miso_o, tx_s[i]);
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            repeat (8) @(negedge clk);
        end
        ss_n_i = 1'b1;
        peek(ADDR_STAT, rd);
        check(rd[7] == 1'b1, "R12 slave done flag", rd[7], 1);
        bus_read(ADDR_DATA, rd);
        check(rd == 8'h96, "R12 slave received byte", rd, 8'h96);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule